// File: doc/BRIEF.md
# Watchdog and Periodic Alarm Down-Counter

This block keeps a 24-bit down-counter together with a seed register that holds the value the counter restarts from. In second mode it counts one-second ticks, raises an alarm flag each time the count runs out, and restarts itself from the seed. In watchdog mode it counts a 4096 Hz tick and stops when it reaches zero. Software keeps the watchdog from expiring by reading any counter byte, which restarts the count from the seed. On expiry the block drives a fixed-width active-low pulse, timed in 1 kHz ticks. A steering bit selects whether the pulse appears on the reset output or on the interrupt output. While a reset pulse is active the block blocks all register access.

The surrounding register file provides per-byte write and read strobes for the counter, a control write strobe and a flag write strobe. The block has no serial bus, oscillator or power-switching logic. The controller is a five-state machine. ST_IDLE holds the counter (disabled, or used as plain storage). ST_SEC_RUN counts seconds. ST_WD_RUN counts watchdog ticks. ST_WD_DONE holds an expired watchdog that produced no pulse. ST_PULSE drives the 250-tick output pulse.

The transitions are as follows:
- ST_IDLE goes to ST_SEC_RUN or ST_WD_RUN once the count is enabled, armed and nonzero. The mode bit picks which.
- The two run states switch between each other when the mode bit changes. They fall back to ST_IDLE when the run condition is lost.
- ST_WD_RUN goes to ST_PULSE on expiry when the pulse is steered to reset, or steered to interrupt with the interrupt enable set. Otherwise it goes to ST_WD_DONE.
- ST_WD_DONE returns to ST_IDLE on a counter write.
- ST_PULSE returns to ST_IDLE when the pulse timer finishes.

Top module: `wdt_alarm_ctrl`

## Requirements
- R1: A write strobe on counter byte k (`cnt_wr[k]`, bits 8k+7..8k) replaces that byte of the seed. The same edge loads the whole counter with the new seed value. Any later reload uses the seed.
- R2: An all-zero counter never counts, whatever the enable bit says. With the enable bit (control bit 3) at 0, the counter holds its value against all ticks, acting as storage.
- R3: In second mode (control bit 2 = 0), each `tick_sec` decrements the count. A tick that arrives at a count of 1 sets `alarm_flag` and reloads the seed, and counting continues.
- R4: In watchdog mode (control bit 2 = 1), each `tick_fast` decrements the count. On reaching zero the flag is set and the counter stops at 0. A strobe on any `cnt_rd` bit before expiry reloads the seed.
- R5: A watchdog expiry with the steering bit (control bit 1) at 0 drives `wdt_rst_n` low for exactly PULSE_TICKS `tick_ms` ticks and raises `access_block`. During this pulse, counter, control and flag writes and counter reads are ignored. The flag clears when the pulse ends.
- R6: An expiry with the steering bit at 1 and the interrupt enable (control bit 0) at 1 drives `wdt_irq_n` low for PULSE_TICKS ticks, and the flag clears at the end. With the interrupt enable at 0, no pulse occurs and the flag stays set until software clears it.
- R7: During a pulse, the pulse cannot be shortened by a flag-clear write or by clearing the interrupt enable, and the flag remains set. A counter written during the pulse loads but does not decrement until the pulse ends.
- R8: In second mode with the interrupt enable set, `wdt_irq_n` is low whenever the flag is 1. A flag write of 0 clears the flag. A flag write of 1 has no effect.
- R9: After a counter write that takes the count from zero to nonzero, the counter stays still until the enable bit is written from 0 to 1.
- R10: When a watchdog tick at count 1 coincides with a read kick, the expiry wins: the counter goes to 0 and the flag sets.
- R11: After reset, the counter and seed are 0, the flag is 0, both outputs are high, `access_block` is low, and all control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | One-cycle strobe at 1 Hz |
| tick_fast | input | 1 | One-cycle strobe at 4096 Hz |
| tick_ms | input | 1 | One-cycle strobe at 1 kHz, used to time the pulse |
| cnt_wr | input | CNT_BYTES | Per-byte counter write strobes |
| cnt_wdata | input | 8 | Counter write byte |
| cnt_rd | input | CNT_BYTES | Per-byte counter read strobes (watchdog kick) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | {enable, mode, steer, irq enable} |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write value (only 0 acts) |
| cnt_value | output | 8*CNT_BYTES | Live counter value |
| alarm_flag | output | 1 | Alarm flag |
| wdt_rst_n | output | 1 | Active-low reset request |
| wdt_irq_n | output | 1 | Active-low interrupt request |
| access_block | output | 1 | High while register access is inhibited |

## Verification
The bench measures each pulse width in cycles while it tries to cut the pulse short with flag clears and interrupt-enable clears. A design with a truncatable pulse would release its output well before 250 ticks. It also issues a read kick on the same cycle as the final watchdog tick. A design that let the kick win would show a reloaded count and no flag. It rewrites a zero counter to nonzero with the enable bit already high, and a design missing the re-arm rule would start counting at once. Writes attempted under a reset pulse are checked to leave the counter and flag untouched.

// File: rtl/wdt_alarm_pkg.sv
package wdt_alarm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEC_RUN = 3'd1,
        ST_WD_RUN  = 3'd2,
        ST_WD_DONE = 3'd3,
        ST_PULSE   = 3'd4
    } wdt_state_e;

    // Control field layout, MSB first: enable, mode, steer, irq enable
    typedef struct packed {
        logic enable;
        logic wdmode;
        logic steer;
        logic irq_en;
    } wdt_ctl_t;

    localparam int unsigned CTL_W = $bits(wdt_ctl_t);

endpackage

// File: rtl/wdt_seed_counter.sv
module wdt_seed_counter #(
    parameter int unsigned CNT_BYTES = 3,
    localparam int unsigned CNT_W = 8 * CNT_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_BYTES-1:0] byte_wr,
    input  logic [7:0]           wdata,
    input  logic                 reload,
    input  logic                 dec,
    output logic [CNT_W-1:0]     cnt_q,
    output logic                 is_zero,
    output logic                 is_one,
    output logic                 wr_from_zero
);

    logic [CNT_W-1:0] seed_q;
    logic [CNT_W-1:0] seed_next;
    logic             any_wr;

    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
        assign seed_next[8*b +: 8] = byte_wr[b] ? wdata : seed_q[8*b +: 8];
    end

    assign any_wr = |byte_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
            cnt_q  <= '0;
        end else if (any_wr) begin
            seed_q <= seed_next;
            cnt_q  <= seed_next;
        end else if (reload) begin
            cnt_q <= seed_q;
        end else if (dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign is_zero      = (cnt_q == '0);
    assign is_one       = (cnt_q == CNT_W'(1));
    assign wr_from_zero = any_wr && is_zero && (seed_next != '0);

    AST_WRITE_LOADS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(any_wr) |-> (cnt_q == seed_q)); // R1

    AST_DEC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !reload && !any_wr && !is_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3

endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
    parameter int unsigned PULSE_TICKS = 250,
    localparam int unsigned CW = $clog2(PULSE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic done
);

    localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q && tick) begin
            if (cnt_q == LAST) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign busy = active_q;
    assign done = active_q && tick && (cnt_q == LAST);

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R5

    AST_DONE_ENDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !active_q); // R7

endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_ok,
    input  wdt_ctl_t   ctl,
    input  logic       tick_sec,
    input  logic       tick_fast,
    input  logic       kick,
    input  logic       cnt_wr_any,
    input  logic       cnt_is_one,
    input  logic       cnt_is_zero,
    input  logic       flag_clr,
    input  logic       pulse_done,
    output wdt_state_e state_q,
    output logic       flag_q,
    output logic       dec,
    output logic       reload,
    output logic       pulse_start,
    output logic       rst_n_out,
    output logic       irq_n_out,
    output logic       access_block
);

    wdt_state_e state_d;
    logic       expire;
    logic       kind_rst_q;

    // Counter actions per state
    always_comb begin : p_actions
        dec    = 1'b0;
        reload = 1'b0;
        expire = 1'b0;
        unique case (state_q)
            ST_SEC_RUN: begin
                if (run_ok && !ctl.wdmode && tick_sec && !cnt_wr_any) begin
                    if (cnt_is_one) begin
                        expire = 1'b1;
                        reload = 1'b1;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            ST_WD_RUN: begin
                if (run_ok && ctl.wdmode && !cnt_wr_any) begin
                    if (tick_fast && cnt_is_one) begin
                        expire = 1'b1;
                        dec    = 1'b1;
                    end else if (kick) begin
                        reload = 1'b1;
                    end else if (tick_fast) begin
                        dec = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    assign pulse_start = (state_q == ST_WD_RUN) && expire && (!ctl.steer || ctl.irq_en);

    // Next-state selection
    always_comb begin : p_next
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_ok) state_d = ctl.wdmode ? ST_WD_RUN : ST_SEC_RUN;
            end
            ST_SEC_RUN: begin
                if (!run_ok)         state_d = ST_IDLE;
                else if (ctl.wdmode) state_d = ST_WD_RUN;
            end
            ST_WD_RUN: begin
                if (expire)           state_d = pulse_start ? ST_PULSE : ST_WD_DONE;
                else if (!run_ok)     state_d = ST_IDLE;
                else if (!ctl.wdmode) state_d = ST_SEC_RUN;
            end
            ST_WD_DONE: begin
                if (cnt_wr_any) state_d = ST_IDLE;
            end
            ST_PULSE: begin
                if (pulse_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin : p_state
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin : p_kind
        if (!rst_n)           kind_rst_q <= 1'b0;
        else if (pulse_start) kind_rst_q <= !ctl.steer;
    end

    always_ff @(posedge clk or negedge rst_n) begin : p_flag
        if (!rst_n)                                  flag_q <= 1'b0;
        else if (expire)                             flag_q <= 1'b1;
        else if (state_q == ST_PULSE && pulse_done)  flag_q <= 1'b0;
        else if (flag_clr && state_q != ST_PULSE)    flag_q <= 1'b0;
    end

    // Outputs
    always_comb begin : p_outputs
        rst_n_out    = !(state_q == ST_PULSE && kind_rst_q);
        access_block =  (state_q == ST_PULSE && kind_rst_q);
        irq_n_out    = !((state_q == ST_PULSE && !kind_rst_q) ||
                         (!ctl.wdmode && ctl.irq_en && flag_q));
    end

    AST_PULSE_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> flag_q); // R7

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WD_DONE) |-> cnt_is_zero); // R4

    AST_ONE_PULSE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n_out |-> irq_n_out); // R5

    AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WD_RUN && tick_fast && cnt_is_one && run_ok && ctl.wdmode && !cnt_wr_any)
        |=> flag_q); // R10

endmodule

// File: rtl/wdt_alarm_ctrl.sv
module wdt_alarm_ctrl
    import wdt_alarm_pkg::*;
#(
    parameter int unsigned CNT_BYTES   = 3,
    parameter int unsigned PULSE_TICKS = 250,
    localparam int unsigned CNT_W = 8 * CNT_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_sec,
    input  logic                 tick_fast,
    input  logic                 tick_ms,
    input  logic [CNT_BYTES-1:0] cnt_wr,
    input  logic [7:0]           cnt_wdata,
    input  logic [CNT_BYTES-1:0] cnt_rd,
    input  logic                 ctl_wr,
    input  logic [3:0]           ctl_wdata,
    input  logic                 flag_wr,
    input  logic                 flag_wdata,
    output logic [CNT_W-1:0]     cnt_value,
    output logic                 alarm_flag,
    output logic                 wdt_rst_n,
    output logic                 wdt_irq_n,
    output logic                 access_block
);

    wdt_ctl_t             ctl_q;
    logic                 armed_q;
    logic [CNT_BYTES-1:0] cnt_wr_g;
    logic                 kick_g;
    logic                 ctl_wr_g;
    logic                 flag_clr_g;
    logic                 cnt_is_zero;
    logic                 cnt_is_one;
    logic                 wr_from_zero;
    logic                 run_ok;
    logic                 dec;
    logic                 reload;
    logic                 pulse_start;
    logic                 pulse_busy;
    logic                 pulse_done;
    wdt_state_e           state;

    // Register access is gated while a reset pulse runs
    assign cnt_wr_g   = access_block ? '0 : cnt_wr;
    assign kick_g     = !access_block && (|cnt_rd);
    assign ctl_wr_g   = !access_block && ctl_wr;
    assign flag_clr_g = !access_block && flag_wr && !flag_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctl_q <= '0;
        else if (ctl_wr_g) ctl_q <= wdt_ctl_t'(ctl_wdata);
    end

    // Enable must rise after a zero-to-nonzero load before counting resumes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        armed_q <= 1'b0;
        else if (ctl_wr_g && ctl_wdata[3] && !ctl_q.enable) armed_q <= 1'b1;
        else if (wr_from_zero)                             armed_q <= 1'b0;
    end

    assign run_ok = ctl_q.enable && armed_q && !cnt_is_zero;

    wdt_seed_counter #(.CNT_BYTES(CNT_BYTES)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_wr      (cnt_wr_g),
        .wdata        (cnt_wdata),
        .reload       (reload),
        .dec          (dec),
        .cnt_q        (cnt_value),
        .is_zero      (cnt_is_zero),
        .is_one       (cnt_is_one),
        .wr_from_zero (wr_from_zero)
    );

    wdt_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pulse_start),
        .tick  (tick_ms),
        .busy  (pulse_busy),
        .done  (pulse_done)
    );

    wdt_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_ok       (run_ok),
        .ctl          (ctl_q),
        .tick_sec     (tick_sec),
        .tick_fast    (tick_fast),
        .kick         (kick_g),
        .cnt_wr_any   (|cnt_wr_g),
        .cnt_is_one   (cnt_is_one),
        .cnt_is_zero  (cnt_is_zero),
        .flag_clr     (flag_clr_g),
        .pulse_done   (pulse_done),
        .state_q      (state),
        .flag_q       (alarm_flag),
        .dec          (dec),
        .reload       (reload),
        .pulse_start  (pulse_start),
        .rst_n_out    (wdt_rst_n),
        .irq_n_out    (wdt_irq_n),
        .access_block (access_block)
    );

    AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_is_zero && !(|cnt_wr_g)) |=> (cnt_value == '0)); // R2

    AST_RUN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (armed_q && ctl_q.enable)); // R9

    AST_PULSE_HAS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> pulse_busy); // R5

    AST_BLOCK_FREEZES_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        access_block |=> $stable(ctl_q)); // R5

endmodule

// File: tb/tb_wdt_alarm_ctrl.sv
module tb_wdt_alarm_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_sec = 1'b0, tick_fast = 1'b0, tick_ms = 1'b0;
    logic [2:0]  cnt_wr = '0, cnt_rd = '0;
    logic [7:0]  cnt_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_wdata = '0;
    logic        flag_wr = 1'b0, flag_wdata = 1'b0;
    logic [23:0] cnt_value;
    logic        alarm_flag, wdt_rst_n, wdt_irq_n, access_block;

    int nvec = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    wdt_alarm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .tick_fast(tick_fast),
        .tick_ms(tick_ms), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rd(cnt_rd),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .cnt_value(cnt_value), .alarm_flag(alarm_flag), .wdt_rst_n(wdt_rst_n),
        .wdt_irq_n(wdt_irq_n), .access_block(access_block)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_byte(input int k, input logic [7:0] d);
        cnt_wr = 3'(1 << k);
        cnt_wdata = d;
        cyc();
        cnt_wr = '0;
    endtask

    task automatic wr_ctl(input logic en, input logic wd, input logic st, input logic ie);
        ctl_wr = 1'b1;
        ctl_wdata = {en, wd, st, ie};
        cyc();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        flag_wr = 1'b1;
        flag_wdata = v;
        cyc();
        flag_wr = 1'b0;
    endtask

    task automatic sec(input int n);
        for (int i = 0; i < n; i++) begin
            tick_sec = 1'b1; cyc(); tick_sec = 1'b0;
        end
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) begin
            tick_fast = 1'b1; cyc(); tick_fast = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    task automatic t_reset();
        check("R11", "cnt", 32'(cnt_value), 0);
        check("R11", "flag", 32'(alarm_flag), 0);
        check("R11", "rst_n", 32'(wdt_rst_n), 1);
        check("R11", "irq_n", 32'(wdt_irq_n), 1);
        check("R11", "block", 32'(access_block), 0);
    endtask

    task automatic t_load_and_store();
        wr_byte(0, 8'h12); wr_byte(1, 8'h34); wr_byte(2, 8'h56);
        check("R1", "byte lanes", 32'(cnt_value), 32'h563412);
        sec(3); fast(3);
        check("R2", "storage with enable off", 32'(cnt_value), 32'h563412);
    endtask

    task automatic t_zero_disable();
        wr_ctl(1, 0, 0, 1);
        wr_byte(2, 8'h00); wr_byte(1, 8'h00); wr_byte(0, 8'h00);
        sec(4);
        check("R2", "zero count held", 32'(cnt_value), 0);
        check("R2", "no flag at zero", 32'(alarm_flag), 0);
    endtask

    task automatic t_rearm();
        wr_byte(0, 8'h05);
        sec(3);
        check("R9", "held until enable rises", 32'(cnt_value), 5);
        wr_ctl(0, 0, 0, 1);
        wr_ctl(1, 0, 0, 1);
        cyc();
        sec(1);
        check("R9", "counts after re-arm", 32'(cnt_value), 4);
    endtask

    task automatic t_second_mode();
        sec(3);
        check("R3", "count at one", 32'(cnt_value), 1);
        check("R8", "irq idle", 32'(wdt_irq_n), 1);
        sec(1);
        check("R3", "reload from seed", 32'(cnt_value), 5);
        check("R3", "flag set", 32'(alarm_flag), 1);
        check("R8", "irq level low", 32'(wdt_irq_n), 0);
        sec(1);
        check("R3", "keeps running", 32'(cnt_value), 4);
        wr_flag(1'b1);
        check("R8", "write 1 no effect", 32'(alarm_flag), 1);
        wr_flag(1'b0);
        check("R8", "write 0 clears", 32'(alarm_flag), 0);
        check("R8", "irq released", 32'(wdt_irq_n), 1);
    endtask

    task automatic t_watchdog_stop();
        wr_ctl(1, 1, 1, 0);
        cyc();
        wr_byte(0, 8'h03);
        fast(1);
        check("R4", "fast decrement", 32'(cnt_value), 2);
        cnt_rd = 3'b010; cyc(); cnt_rd = '0;
        check("R4", "kick reloads seed", 32'(cnt_value), 3);
        fast(2);
        tick_fast = 1'b1; cnt_rd = 3'b001; cyc(); tick_fast = 1'b0; cnt_rd = '0;
        check("R10", "expiry beats kick cnt", 32'(cnt_value), 0);
        check("R10", "expiry beats kick flag", 32'(alarm_flag), 1);
        check("R6", "no irq pulse when disabled", 32'(wdt_irq_n), 1);
        check("R6", "no reset pulse", 32'(wdt_rst_n), 1);
        fast(3);
        check("R4", "stopped at zero", 32'(cnt_value), 0);
        check("R6", "flag held", 32'(alarm_flag), 1);
        wr_flag(1'b0);
        check("R6", "software clear", 32'(alarm_flag), 0);
    endtask

    task automatic t_reset_pulse();
        int n;
        wr_byte(0, 8'h02);
        wr_ctl(0, 1, 0, 0);
        wr_ctl(1, 1, 0, 0);
        cyc();
        fast(2);
        check("R5", "reset low", 32'(wdt_rst_n), 0);
        check("R5", "block high", 32'(access_block), 1);
        check("R5", "irq stays high", 32'(wdt_irq_n), 1);
        tick_ms = 1'b1;
        cnt_wr = 3'b001; cnt_wdata = 8'h77; flag_wr = 1'b1; flag_wdata = 1'b0;
        cyc();
        cnt_wr = '0; flag_wr = 1'b0;
        n = 1;
        check("R5", "write ignored", 32'(cnt_value), 0);
        check("R5", "flag clear ignored", 32'(alarm_flag), 1);
        while (wdt_rst_n == 1'b0 && n < 400) begin cyc(); n++; end
        tick_ms = 1'b0;
        check("R5", "pulse width", 32'(n), 250);
        check("R5", "flag cleared at end", 32'(alarm_flag), 0);
        check("R5", "block released", 32'(access_block), 0);
    endtask

    task automatic t_irq_pulse();
        int n;
        wr_byte(0, 8'h02);
        wr_ctl(0, 1, 1, 1);
        wr_ctl(1, 1, 1, 1);
        cyc();
        fast(2);
        check("R6", "irq low", 32'(wdt_irq_n), 0);
        check("R6", "reset high", 32'(wdt_rst_n), 1);
        check("R6", "no block", 32'(access_block), 0);
        tick_ms = 1'b1; tick_fast = 1'b1;
        wr_flag(1'b0);
        wr_ctl(1, 1, 1, 0);
        wr_byte(0, 8'h04);
        wr_ctl(0, 1, 1, 1);
        wr_ctl(1, 1, 1, 1);
        tick_fast = 1'b0;
        n = 5;
        check("R7", "no decrement in pulse", 32'(cnt_value), 4);
        check("R7", "flag kept in pulse", 32'(alarm_flag), 1);
        check("R7", "irq still low", 32'(wdt_irq_n), 0);
        while (wdt_irq_n == 1'b0 && n < 400) begin cyc(); n++; end
        tick_ms = 1'b0;
        check("R7", "pulse not shortened", 32'(n), 250);
        check("R6", "flag cleared at end", 32'(alarm_flag), 0);
        cyc();
        fast(1);
        check("R7", "counts after pulse", 32'(cnt_value), 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        t_reset();
        t_load_and_store();
        t_zero_disable();
        t_rearm();
        t_second_mode();
        t_watchdog_stop();
        t_reset_pulse();
        t_irq_pulse();
        finish_run();
    end

endmodule